// File: doc/BRIEF.md
# Noughts-and-Crosses Board Status Evaluator

This block looks at a square noughts-and-crosses grid, three cells on a side by default, and reports where the game stands. It takes two occupancy masks, one for X and one for O, with one bit per cell. Bit `i` is the cell in row `i / SIDE` and column `i % SIDE`.

Five status flags are produced: illegal board, board full, X has won, O has won, and game still open. The decision is combinational. All five flags are captured in one register stage, so they follow the masks one clock later.

Both masks are sampled on every rising edge; there is no handshake. A surrounding controller places the masks it wants judged on the inputs and reads the flags one cycle later. Move sequencing and turn-order rules belong to that controller.

Top module: `ttt_board_eval`

## Requirements
- R1: Cell bit `i` of either mask is row `i / SIDE`, column `i % SIDE`. There are exactly 2*SIDE+2 winning lines: every row, every column, the main diagonal (cells r*SIDE+r) and the anti-diagonal (cells r*SIDE+SIDE-1-r).
- R2: `illegal` is set when at least one cell has its bit set in both `x_cells` and `o_cells`.
- R3: `illegal` is set when both X and O each hold a complete winning line, even with no shared cell.
- R4: While `illegal` is set, `board_full`, `x_won`, `o_won` and `in_play` are all 0.
- R5: `board_full` is set when every cell is marked by X or O and the board is not illegal.
- R6: `x_won` is set when X occupies every cell of at least one winning line and the board is not illegal.
- R7: `o_won` is set when O occupies every cell of at least one winning line and the board is not illegal.
- R8: `in_play` is set only when the board is not illegal, nobody has won and at least one cell is empty.
- R9: Every flag reflects the masks sampled at the previous rising clock edge, and it holds until the next edge.
- R10: While `rst` is high at a rising edge, all five flags become 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_cells | input | SIDE*SIDE | Cells holding an X, bit i = row i/SIDE, column i%SIDE |
| o_cells | input | SIDE*SIDE | Cells holding an O, same layout |
| illegal | output | 1 | Board cannot occur in a legal game |
| board_full | output | 1 | No empty cell left |
| x_won | output | 1 | X holds a winning line |
| o_won | output | 1 | O holds a winning line |
| in_play | output | 1 | Game not yet decided |

## Verification
Several flags can be due from the same board. The most telling pair is a full grid that also contains a winning line: `board_full` and a win flag must both come up in the same cycle, while `in_play` stays low. The bench provokes this by filling the last cell so that the final mark closes a line.

A second pair sets a win and a shared cell together. A double win with no shared cell must also be judged illegal. In every such case the bench compares all five flags, one cycle after the masks are applied, against its own rule model.

// File: rtl/ttt_pkg.sv
package ttt_pkg;

  // Registered verdict; field order is fixed so the five flags can be packed together.
  typedef struct packed {
    logic illegal;
    logic full;
    logic x_won;
    logic o_won;
    logic in_play;
  } verdict_t;

  localparam verdict_t VERDICT_CLEAR = '{default: 1'b0};

endpackage

// File: rtl/ttt_line_scan.sv
// Reports whether one player's marks cover any complete winning line.
module ttt_line_scan #(
  parameter int SIDE = 3
) (
  input  logic [SIDE*SIDE-1:0] marks,
  output logic                 any_line
);
  localparam int CELLS = SIDE * SIDE;
  localparam int LINES = 2 * SIDE + 2;

  // Mask of cells in line k: rows first, then columns, then the two diagonals.
  function automatic logic [CELLS-1:0] line_cells(input int k);
    logic [CELLS-1:0] m;
    m = '0;
    for (int p = 0; p < SIDE; p++) begin
      if (k < SIDE)            m[k * SIDE + p]                 = 1'b1;
      else if (k < 2 * SIDE)   m[p * SIDE + (k - SIDE)]        = 1'b1;
      else if (k == 2 * SIDE)  m[p * SIDE + p]                 = 1'b1;
      else                     m[p * SIDE + (SIDE - 1 - p)]    = 1'b1;
    end
    return m;
  endfunction

  logic [LINES-1:0] line_hit;

  generate
    for (genvar k = 0; k < LINES; k++) begin : g_line
      localparam logic [CELLS-1:0] LMASK = line_cells(k);
      assign line_hit[k] = &(marks | ~LMASK);
    end
  endgenerate

  assign any_line = |line_hit;
endmodule

// File: rtl/ttt_cell_census.sv
// Cell-wise checks: shared cells and absence of empty cells.
module ttt_cell_census #(
  parameter int CELLS = 9
) (
  input  logic [CELLS-1:0] x_marks,
  input  logic [CELLS-1:0] o_marks,
  output logic             clash,
  output logic             no_empty
);
  assign clash    = |(x_marks & o_marks);
  assign no_empty = &(x_marks | o_marks);
endmodule

// File: rtl/ttt_verdict.sv
// Folds the raw findings into one consistent set of flags.
module ttt_verdict
  import ttt_pkg::*;
(
  input  logic     clash,
  input  logic     no_empty,
  input  logic     x_line,
  input  logic     o_line,
  output verdict_t verdict
);
  logic bad;

  always_comb begin
    bad = clash | (x_line & o_line);
    verdict         = VERDICT_CLEAR;
    verdict.illegal = bad;
    if (!bad) begin
      verdict.full    = no_empty;
      verdict.x_won   = x_line;
      verdict.o_won   = o_line;
      verdict.in_play = ~(no_empty | x_line | o_line);
    end
  end
endmodule

// File: rtl/ttt_board_eval.sv
module ttt_board_eval
  import ttt_pkg::*;
#(
  parameter int SIDE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SIDE*SIDE-1:0] x_cells,
  input  logic [SIDE*SIDE-1:0] o_cells,
  output logic                 illegal,
  output logic                 board_full,
  output logic                 x_won,
  output logic                 o_won,
  output logic                 in_play
);
  localparam int CELLS = SIDE * SIDE;

  logic     clash, no_empty, x_line, o_line;
  verdict_t next_v, held_v;

  ttt_cell_census #(.CELLS(CELLS)) u_census (
    .x_marks (x_cells),
    .o_marks (o_cells),
    .clash   (clash),
    .no_empty(no_empty)
  );

  ttt_line_scan #(.SIDE(SIDE)) u_scan_x (.marks(x_cells), .any_line(x_line));
  ttt_line_scan #(.SIDE(SIDE)) u_scan_o (.marks(o_cells), .any_line(o_line));

  ttt_verdict u_verdict (
    .clash   (clash),
    .no_empty(no_empty),
    .x_line  (x_line),
    .o_line  (o_line),
    .verdict (next_v)
  );

  always_ff @(posedge clk) begin
    if (rst) held_v <= VERDICT_CLEAR;
    else     held_v <= next_v;
  end

  assign illegal    = held_v.illegal;
  assign board_full = held_v.full;
  assign x_won      = held_v.x_won;
  assign o_won      = held_v.o_won;
  assign in_play    = held_v.in_play;
endmodule

// File: rtl/ttt_board_eval_chk.sv
module ttt_board_eval_chk #(
  parameter int SIDE = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [SIDE*SIDE-1:0] x_cells,
  input logic [SIDE*SIDE-1:0] o_cells,
  input logic                 illegal,
  input logic                 board_full,
  input logic                 x_won,
  input logic                 o_won,
  input logic                 in_play
);
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> !(illegal || board_full || x_won || o_won || in_play));

  assert_shared_cell_R2: assert property (@(posedge clk) disable iff (rst)
    (|(x_cells & o_cells)) |=> illegal);

  assert_illegal_masks_R4: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !(board_full || x_won || o_won || in_play));

  assert_single_winner_R3: assert property (@(posedge clk) disable iff (rst)
    !(x_won && o_won));

  assert_play_needs_gap_R8: assert property (@(posedge clk) disable iff (rst)
    in_play |-> !(board_full || x_won || o_won));

  assert_full_from_masks_R5: assert property (@(posedge clk) disable iff (rst)
    (!(&(x_cells | o_cells))) |=> !board_full);

  assert_some_flag_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (illegal || board_full || x_won || o_won || in_play));
endmodule

bind ttt_board_eval ttt_board_eval_chk #(.SIDE(SIDE)) u_chk (.*);

// File: tb/tb_ttt_board_eval.sv
module tb_ttt_board_eval;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] x_cells = '0;
  logic [8:0] o_cells = '0;
  logic       illegal, board_full, x_won, o_won, in_play;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ttt_board_eval #(.SIDE(3)) dut (
    .clk(clk), .rst(rst), .x_cells(x_cells), .o_cells(o_cells),
    .illegal(illegal), .board_full(board_full), .x_won(x_won),
    .o_won(o_won), .in_play(in_play)
  );

  // Winning lines written out: bit i = row i/3, column i%3 (R1).
  localparam logic [8:0] LINE_SET [8] = '{9'h007, 9'h038, 9'h1C0, 9'h049,
                                          9'h092, 9'h124, 9'h111, 9'h054};

  function automatic logic has_line(input logic [8:0] m);
    has_line = 1'b0;
    for (int k = 0; k < 8; k++) if ((m & LINE_SET[k]) == LINE_SET[k]) has_line = 1'b1;
  endfunction

  // Expected flags {illegal, full, x_won, o_won, in_play}.
  function automatic logic [4:0] model(input logic [8:0] xm, input logic [8:0] om);
    logic bad, xl, ol, fl;
    xl  = has_line(xm);
    ol  = has_line(om);
    fl  = ((xm | om) == 9'h1FF);
    bad = ((xm & om) != 0) || (xl && ol);
    if (bad) model = 5'b10000;
    else     model = {1'b0, fl, xl, ol, !(fl || xl || ol)};
  endfunction

  function automatic logic [4:0] flags();
    flags = {illegal, board_full, x_won, o_won, in_play};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if (flags() !== exp) begin
      failures++;
      $display("FAIL %s flags actual=%b expected=%b", req, flags(), exp);
    end
  endtask

  // Drive masks away from the edge, let one edge capture, sample at the next negedge.
  task automatic apply(input logic [8:0] xm, input logic [8:0] om, input string req);
    @(negedge clk);
    x_cells = xm;
    o_cells = om;
    @(negedge clk);
    check(req, model(xm, om));
  endtask

  task automatic t_reset_state();
    check("R10 reset", 5'b00000);
  endtask

  task automatic t_empty_board();
    apply(9'h000, 9'h000, "R8 empty board in play");
    check("R8 empty explicit", 5'b00001);
  endtask

  task automatic t_every_line();
    for (int k = 0; k < 8; k++) begin
      apply(LINE_SET[k], 9'h000, "R1 R6 x line");
      check("R6 x line explicit", 5'b00100);
      apply(9'h000, LINE_SET[k], "R1 R7 o line");
      check("R7 o line explicit", 5'b00010);
    end
    apply(9'h0A1, 9'h000, "R1 non-line shape");  // cells 0,5,7: no line
  endtask

  task automatic t_conflict();
    apply(9'h010, 9'h010, "R2 shared center");
    check("R2 R4 shared explicit", 5'b10000);
    apply(9'h007, 9'h104, "R2 R4 shared with x line");
    check("R4 masks win", 5'b10000);
  endtask

  task automatic t_double_win();
    apply(9'h007, 9'h1C0, "R3 both win");
    check("R3 both win explicit", 5'b10000);
  endtask

  task automatic t_full_boards();
    apply(9'h18D, 9'h072, "R5 draw");
    check("R5 draw explicit", 5'b01000);
    apply(9'h097, 9'h168, "R5 R6 full with x win");
    check("R5 R6 full win explicit", 5'b01100);
  endtask

  task automatic t_partial();
    apply(9'h011, 9'h002, "R8 partial");
    check("R8 partial explicit", 5'b00001);
  endtask

  task automatic t_latency();
    apply(9'h000, 9'h000, "R9 setup");
    @(negedge clk);
    x_cells = 9'h111;
    #1;
    check("R9 holds before edge", 5'b00001);
    @(posedge clk);
    #1;
    check("R9 updates after edge", 5'b00100);
  endtask

  task automatic t_mid_reset();
    apply(9'h038, 9'h000, "R10 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset", 5'b00000);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", model(9'h038, 9'h000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_empty_board();
    t_every_line();
    t_conflict();
    t_double_win();
    t_full_boards();
    t_partial();
    t_latency();
    t_mid_reset();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule